// File: doc/BRIEF.md
# Quad Gated-Clock D Flip-Flop

This block holds four independent data bits. Each bit has a master/slave storage pair that is clocked by its own effective clock: the OR of one shared common clock input and that bit's own enable input. Two ways of using it follow from this. In common clocking the enables rest LOW and the common clock strobes all four bits; an enable held HIGH then shields its bit from common-clock edges. In per-bit clocking the common clock rests LOW and each enable acts as the clock of its own bit.

Every bit has its own active-HIGH clear input. Two active-HIGH preset inputs each drive a fixed pair of bits: one pair is bits 0 and 3, the other is bits 1 and 2. Clear and preset override the stored value at the outputs straight away. The stored value then stays put after release until the next effective rising edge. Each bit drives a true output and a complementary output.

The gated clock inputs are treated as data. They are sampled on a free-running system clock, and an effective edge is found by comparing two consecutive samples. A synchronous active-LOW system reset puts the block into a known state.

Top module: `quad_gated_dff`

## Requirements
- R1: While `rst_n` is LOW at a rising `clk` edge, the master and slave of every bit are cleared. With clear and preset inputs inactive, this gives `q` = 0 and `q_n` = 4'hF after that edge.
- R2: The master of bit i loads `din[i]` at every `clk` edge at which its effective clock (`com_clk | elem_en[i]`) is LOW. A change of `din[i]` while the effective clock is HIGH has no effect on the value that is captured.
- R3: When a `clk` edge sees the effective clock of bit i HIGH, and the previous edge saw it LOW, the slave takes the master's value. `q[i]` shows that value right after this edge. Data must therefore be present at least one sample before the sample at which the effective clock is first seen HIGH.
- R4: In common clocking (all `elem_en` LOW), a rising `com_clk` updates all four bits at the same edge.
- R5: A bit whose `elem_en` is held HIGH ignores `com_clk` edges. With `com_clk` LOW, a rising `elem_en[i]` updates bit i alone.
- R6: With no effective rising edge and no clear or preset active, `q` is unchanged; a falling effective clock captures nothing.
- R7: `clr[i]` HIGH forces `q[i]` LOW at once, without waiting for a `clk` edge, whatever the clocks are doing.
- R8: `preset_a` HIGH forces bits 0 and 3 HIGH, and `preset_b` HIGH forces bits 1 and 2 HIGH. The bits outside the pair keep their values.
- R9: When `clr[i]` and the preset of bit i's pair are both HIGH, the clear wins and `q[i]` is LOW.
- R10: After a clear or preset is released, the bit keeps the forced value until its next effective rising edge.
- R11: `q_n` is always the bitwise inverse of `q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Synchronous active-LOW system reset |
| com_clk | input | 1 | Common clock shared by all bits |
| elem_en | input | 4 | Per-bit enable, also usable as per-bit clock |
| din | input | 4 | Data inputs, bit i feeds element i |
| clr | input | 4 | Per-bit active-HIGH clear |
| preset_a | input | 1 | Active-HIGH preset of bits 0 and 3 |
| preset_b | input | 1 | Active-HIGH preset of bits 1 and 2 |
| q | output | 4 | True outputs |
| q_n | output | 4 | Complementary outputs |

## Verification
The assertions assume that `com_clk`, `elem_en`, `din`, `clr` and the presets are synchronous to `clk`. They also assume that no pulse on these inputs is shorter than one `clk` period, because the capture and hold properties reason sample by sample. The stimulus keeps to this. Every input is changed only at the falling edge of `clk`, and each level is held for at least one full period. As a result each gated-clock edge, clear and preset is seen by exactly one sampling edge.

// File: rtl/quad_dff_pkg.sv
// Package: shared constants and the fixed preset pairing of the quad
// gated-clock flip-flop.
// Assumes: pairing is by chip symmetry, the outer bits form one group and
// the inner bits the other.
package quad_dff_pkg;

    localparam int NUM_ELEM  = 4;
    localparam int NUM_PAIRS = 2;

    // Group index of the preset that drives bit idx of an n-bit array.
    function automatic int pair_group(input int idx, input int n);
        return ((idx == 0) || (idx == n - 1)) ? 0 : 1;
    endfunction

endpackage

// File: rtl/gclk_edge_det.sv
// Module: gclk_edge_det
// Forms the effective clock of one bit (common clock OR enable) and flags
// a rising edge of it between two consecutive system clock samples.
// Assumes: both inputs are synchronous to clk and last at least one period.
module gclk_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic com_clk,
    input  logic en,
    output logic eff,
    output logic rise
);

    logic eff_prev;

    // Effective clock is the OR of common clock and per-bit enable.
    always_comb eff = com_clk | en;

    // Remember the previous sample of the effective clock.
    always_ff @(posedge clk) begin
        if (!rst_n) eff_prev <= 1'b0;
        else        eff_prev <= eff;
    end

    // Rising edge: HIGH now, LOW at the previous sample.
    always_comb rise = eff & ~eff_prev;

endmodule

// File: rtl/preset_router.sv
// Module: preset_router
// Spreads the paired preset inputs onto the bits they control.
// Assumes: NUM_PAIRS is 2 and the pairing follows quad_dff_pkg::pair_group.
module preset_router
    import quad_dff_pkg::*;
#(
    parameter int N = NUM_ELEM
) (
    input  logic [NUM_PAIRS-1:0] preset_grp,
    output logic [N-1:0]         preset_bit
);

    for (genvar i = 0; i < N; i++) begin : g_route
        localparam int Grp = pair_group(i, N);
        // Each bit follows the preset of its group.
        always_comb preset_bit[i] = preset_grp[Grp];
    end

endmodule

// File: rtl/dff_cell.sv
// Module: dff_cell
// One master/slave storage bit with overriding clear and preset.
// Assumes: eff and rise come from gclk_edge_det; clr beats preset; the
// overrides act on the outputs at once and are also written into the slave.
module dff_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic eff,
    input  logic rise,
    input  logic d,
    input  logic clr,
    input  logic preset,
    output logic q,
    output logic q_n
);

    logic master;
    logic slave;

    // Master follows the data while the effective clock is LOW.
    always_ff @(posedge clk) begin
        if (!rst_n)   master <= 1'b0;
        else if (!eff) master <= d;
    end

    // Slave takes the override value, else the master on an effective edge.
    always_ff @(posedge clk) begin
        if (!rst_n)       slave <= 1'b0;
        else if (clr)     slave <= 1'b0;
        else if (preset)  slave <= 1'b1;
        else if (rise)    slave <= master;
    end

    // Outputs reflect overrides without waiting for a sample.
    always_comb begin
        if (clr)         q = 1'b0;
        else if (preset) q = 1'b1;
        else             q = slave;
        q_n = ~q;
    end

    assert_master_track_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !eff |=> (master == $past(d)));

    assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && !clr && !preset) |=> (slave == $past(master)));

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise && !clr && !preset) |=> $stable(slave));

    assert_clear_stored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !slave);

    assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && preset) |-> !q);

endmodule

// File: rtl/quad_gated_dff.sv
// Module: quad_gated_dff (top)
// Four gated-clock D flip-flops with per-bit clear and paired presets.
// Assumes: all inputs are synchronous to clk; preset_a drives the outer
// bits (0 and N-1), preset_b the inner bits.
module quad_gated_dff
    import quad_dff_pkg::*;
#(
    parameter int N = NUM_ELEM
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         com_clk,
    input  logic [N-1:0] elem_en,
    input  logic [N-1:0] din,
    input  logic [N-1:0] clr,
    input  logic         preset_a,
    input  logic         preset_b,
    output logic [N-1:0] q,
    output logic [N-1:0] q_n
);

    logic [NUM_PAIRS-1:0] preset_grp;
    logic [N-1:0]         preset_bit;
    logic [N-1:0]         eff;
    logic [N-1:0]         rise;

    // Bundle the two preset inputs by group index.
    always_comb preset_grp = {preset_b, preset_a};

    preset_router #(.N(N)) i_router (
        .preset_grp (preset_grp),
        .preset_bit (preset_bit)
    );

    for (genvar i = 0; i < N; i++) begin : g_elem
        gclk_edge_det i_edge (
            .clk     (clk),
            .rst_n   (rst_n),
            .com_clk (com_clk),
            .en      (elem_en[i]),
            .eff     (eff[i]),
            .rise    (rise[i])
        );

        dff_cell i_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .eff    (eff[i]),
            .rise   (rise[i]),
            .d      (din[i]),
            .clr    (clr[i]),
            .preset (preset_bit[i]),
            .q      (q[i]),
            .q_n    (q_n[i])
        );

        assert_pair_preset_R8: assert property (@(posedge clk) disable iff (!rst_n)
            ((pair_group(i, N) == 0 ? preset_a : preset_b) && !clr[i]) |-> q[i]);

        assert_blocked_by_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(elem_en[i]) && elem_en[i] && !clr[i] && !preset_bit[i]) |=> $stable(q[i]));
    end

endmodule

// File: tb/test_quad_gated_dff.sv
module test_quad_gated_dff;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       com_clk = 1'b0;
    logic [3:0] elem_en = '0;
    logic [3:0] din = '0;
    logic [3:0] clr = '0;
    logic       preset_a = 1'b0;
    logic       preset_b = 1'b0;
    logic [3:0] q;
    logic [3:0] q_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [3:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    quad_gated_dff i_quad_gated_dff (
        .clk(clk), .rst_n(rst_n), .com_clk(com_clk), .elem_en(elem_en),
        .din(din), .clr(clr), .preset_a(preset_a), .preset_b(preset_b),
        .q(q), .q_n(q_n)
    );

    task automatic compare(input logic [3:0] e, input string tag);
        checks++;
        if (q !== e) begin
            fails++;
            $display("FAIL %s: q=%b expected %b", tag, q, e);
        end
        checks++;
        if (q_n !== ~e) begin
            fails++;
            $display("FAIL R11: q_n=%b expected %b", q_n, ~e);
        end
    endtask

    // Monitor: after each sampling edge, compare against the scoreboard.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
        end
    end

    // Driver: apply one sample worth of inputs and queue the expected result.
    task automatic step(input logic c, input logic [3:0] en, input logic [3:0] d,
                        input logic [3:0] cl, input logic pa, input logic pb,
                        input logic [3:0] e, input string tag);
        @(negedge clk);
        com_clk = c; elem_en = en; din = d; clr = cl; preset_a = pa; preset_b = pb;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        checks++; fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        // R1: held in reset with data present
        step(1'b0, 4'h0, 4'hF, 4'h0, 1'b0, 1'b0, 4'h0, "R1");
        step(1'b0, 4'h0, 4'hF, 4'h0, 1'b0, 1'b0, 4'h0, "R1");
        @(negedge clk); rst_n = 1'b1;
        step(1'b0, 4'h0, 4'hA, 4'h0, 1'b0, 1'b0, 4'h0, "R6");
        // R4: common clock rising updates all bits
        step(1'b1, 4'h0, 4'hA, 4'h0, 1'b0, 1'b0, 4'hA, "R4");
        // R2: data change while clock HIGH is ignored
        step(1'b1, 4'h0, 4'h5, 4'h0, 1'b0, 1'b0, 4'hA, "R2");
        // R6: falling edge captures nothing
        step(1'b0, 4'h0, 4'h5, 4'h0, 1'b0, 1'b0, 4'hA, "R6");
        // R5: enable rising clocks its bit alone
        step(1'b0, 4'h4, 4'h5, 4'h0, 1'b0, 1'b0, 4'hE, "R5");
        step(1'b0, 4'h4, 4'h0, 4'h0, 1'b0, 1'b0, 4'hE, "R6");
        // R5: enable held HIGH blocks the common clock
        step(1'b1, 4'h4, 4'h0, 4'h0, 1'b0, 1'b0, 4'h4, "R5");
        step(1'b0, 4'h0, 4'hF, 4'h0, 1'b0, 1'b0, 4'h4, "R6");
        // R5: per-bit clocking with common clock LOW
        step(1'b0, 4'h1, 4'hF, 4'h0, 1'b0, 1'b0, 4'h5, "R5");
        step(1'b0, 4'h0, 4'hF, 4'h0, 1'b0, 1'b0, 4'h5, "R6");
        step(1'b0, 4'h8, 4'hF, 4'h0, 1'b0, 1'b0, 4'hD, "R5");
        step(1'b0, 4'h0, 4'h0, 4'h0, 1'b0, 1'b0, 4'hD, "R6");
        // R7: clear of bit 0, then R10 hold after release
        step(1'b0, 4'h0, 4'h0, 4'h1, 1'b0, 1'b0, 4'hC, "R7");
        step(1'b0, 4'h0, 4'h0, 4'h0, 1'b0, 1'b0, 4'hC, "R10");
        // R8: preset_b sets bits 1 and 2 only
        step(1'b0, 4'h0, 4'h0, 4'h0, 1'b0, 1'b1, 4'hE, "R8");
        step(1'b0, 4'h0, 4'h0, 4'h0, 1'b0, 1'b0, 4'hE, "R10");
        // R7: clear acts before any sampling edge
        @(negedge clk);
        clr = 4'hF;
        #0.5;
        compare(4'h0, "R7");
        exp_q.push_back(4'h0); tag_q.push_back("R7");
        step(1'b0, 4'h0, 4'h0, 4'h0, 1'b0, 1'b0, 4'h0, "R10");
        // R8: preset_a sets bits 0 and 3 only
        step(1'b0, 4'h0, 4'h0, 4'h0, 1'b1, 1'b0, 4'h9, "R8");
        // R9: clear beats preset on bit 3
        step(1'b0, 4'h0, 4'h0, 4'h8, 1'b1, 1'b0, 4'h1, "R9");
        step(1'b0, 4'h0, 4'h0, 4'h0, 1'b0, 1'b0, 4'h1, "R10");
        // R3: next effective edge after release captures the master
        step(1'b1, 4'h0, 4'h0, 4'h0, 1'b0, 1'b0, 4'h0, "R3");
        step(1'b0, 4'h0, 4'h6, 4'h0, 1'b0, 1'b0, 4'h0, "R6");
        step(1'b1, 4'h0, 4'h6, 4'h0, 1'b0, 1'b0, 4'h6, "R4");
        step(1'b1, 4'h0, 4'h6, 4'h0, 1'b0, 1'b0, 4'h6, "R6");
        @(posedge clk); #2;
        finish_run();
    end

endmodule